// File: doc/BRIEF.md
# Two-Phase Configuration Access Sequencer

This block takes one configuration request from a host (target slot, function, byte offset, access size, direction and write data) and carries it out on a plain register bus as a two-phase cycle. First it writes an encoded control word into an address/control register. That write points a shared IO window at the chosen configuration register. Then it moves the data through that window. At the end it writes zero to the control register, so the window goes back to ordinary IO use.

Writes narrower than a dword are done as read-modify-write. The block reads the whole dword from the window, merges the new bytes into their lane, and writes the whole dword back. After a window write the target gives no completion signal. The block therefore waits a fixed time, set by a clock-frequency parameter, before it restores the window. A target whose fields do not fit the control word is refused with a not-found status and the bus is not touched. So is a root-bus access to the slot reserved for a bridge.

Top module: `cfg_cycle_seq`

## Requirements
- R1: The control word holds use-register at bit 0, config-select at bit 1, and the cycle-type bit at bit 2. The type bit is 1 only when `req_root` is 0. The register index sits at bits [3 +: REG_W], the function at [3+REG_W +: FUNC_W] and the slot at [3+REG_W+FUNC_W +: SLOT_W]. All higher bits are zero.
- R2: The register index is the byte offset `req_where` shifted right by two.
- R3: A slot above 2^SLOT_W-1, a function above 2^FUNC_W-1 or a register index above 2^REG_W-1 is refused. The response comes in the cycle after acceptance with `rsp_notfound`=1 and `rsp_rdata`=0. The bus is never strobed for such a request.
- R4: When `req_root`=1 and the slot equals BRIDGE_SLOT, the request is refused as in R3. The same slot is accepted when `req_root`=0.
- R5: An accepted request produces bus strobes in this order:
  - a control write (`bus_win`=0);
  - one cycle later, a window read (`bus_win`=1);
  - two cycles after the read, either a window write (for a write request) or the restore write;
  - the restore, a control write of zero.
  `bus_rdata` must be valid from the clock edge that follows the one that sampled `bus_rd`.
- R6: Size codes are 0 = byte, 1 = half-word, 2 or 3 = dword.
  - For a byte or half-word read, `rsp_rdata` is the window dword shifted right by 8×`req_where[1:0]` and masked to 0xFF or 0xFFFF.
  - A dword read returns the window dword unchanged.
  - Bytes are never reordered.
- R7: A write puts the merged dword on the window. The merge clears the lane mask (0xFF or 0xFFFF shifted left by 8×`req_where[1:0]`, kept to 32 bits) and ORs in the same-width low bits of `req_wdata`, shifted the same way. A dword write replaces the whole dword.
- R8: After the window write there are exactly WAIT_CYC = CLK_HZ/1e6 × WAIT_US cycles with no bus strobe before the restore write.
- R9: `busy` stays high from acceptance until the response has been given. A `req_valid` pulse while `busy` is high is ignored.
- R10: `rsp_valid` is a one-cycle pulse in the cycle after the restore write. `busy` is low in the next cycle. A write response carries `rsp_rdata`=0. After reset, `busy`, `rsp_valid`, `bus_wr` and `bus_rd` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when `busy` is low |
| req_root | input | 1 | 1: target sits on the root bus (type 0 cycle) |
| req_slot | input | 5 | Target slot number |
| req_func | input | 3 | Target function number |
| req_where | input | 8 | Byte offset in configuration space |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 dword |
| req_write | input | 1 | 1: write, 0: read |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Sequencer occupied |
| rsp_valid | output | 1 | Response pulse |
| rsp_notfound | output | 1 | Target refused |
| rsp_rdata | output | 32 | Read data, right-aligned |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_win | output | 1 | 0: control register, 1: data window |
| bus_wdata | output | 32 | Register write data |
| bus_rdata | input | 32 | Register read data |

## Verification
The bench aims at five boundaries:
- the highest legal slot, function and register index, next to the first values one past them;
- the reserved bridge slot, on the root bus and off it;
- a half-word at lane 3, whose mask is cut to a single byte;
- byte writes into a lane that already holds data;
- a request pulse in the middle of the write wait.

A wrong range test either puts strobes on the bus for a refused target or refuses a legal one. A wrong lane shift corrupts the neighbouring bytes on read-back. A wait that is off by one moves the restore strobe away from the counted cycle. A sequencer that does not hold off new requests while busy puts strobes on the bus that the model never expects.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  localparam int DWORD_W = 32;

  typedef enum logic [2:0] {
    S_IDLE, S_CTRL, S_RDREQ, S_RDCAP, S_WRWIN, S_WAIT, S_REST, S_RESP
  } seq_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/cfgseq_encode.sv
module cfgseq_encode
  import cfgseq_pkg::*;
#(
  parameter int SLOT_W      = 4,
  parameter int FUNC_W      = 2,
  parameter int REG_W       = 4,
  parameter int BRIDGE_SLOT = 8
) (
  input  logic               root,
  input  logic [4:0]         slot,
  input  logic [2:0]         func,
  input  logic [7:0]         where_b,
  output logic               ok,
  output logic [DWORD_W-1:0] ctrl
);
  localparam int FUNC_LSB = 3 + REG_W;
  localparam int SLOT_LSB = FUNC_LSB + FUNC_W;
  localparam logic [7:0] SLOT_MAX = 8'((1 << SLOT_W) - 1);
  localparam logic [7:0] FUNC_MAX = 8'((1 << FUNC_W) - 1);
  localparam logic [7:0] REG_MAX  = 8'((1 << REG_W) - 1);

  logic [5:0] reg_idx;
  logic       slot_bad, func_bad, reg_bad, bridge_hit;

  assign reg_idx    = where_b[7:2];
  assign slot_bad   = {3'b000, slot} > SLOT_MAX;
  assign func_bad   = {5'b00000, func} > FUNC_MAX;
  assign reg_bad    = {2'b00, reg_idx} > REG_MAX;
  assign bridge_hit = root && (slot == 5'(BRIDGE_SLOT));
  assign ok         = !(slot_bad || func_bad || reg_bad || bridge_hit);

  always_comb begin
    ctrl = '0;
    ctrl[0] = 1'b1;
    ctrl[1] = 1'b1;
    ctrl[2] = ~root;
    ctrl[3 +: REG_W]         = reg_idx[REG_W-1:0];
    ctrl[FUNC_LSB +: FUNC_W] = func[FUNC_W-1:0];
    ctrl[SLOT_LSB +: SLOT_W] = slot[SLOT_W-1:0];
  end
endmodule

// File: rtl/cfgseq_lane.sv
module cfgseq_lane
  import cfgseq_pkg::*;
(
  input  logic [1:0]         size,
  input  logic [1:0]         lane,
  input  logic [DWORD_W-1:0] win_data,
  input  logic [DWORD_W-1:0] new_data,
  output logic [DWORD_W-1:0] rd_data,
  output logic [DWORD_W-1:0] merged
);
  logic [DWORD_W-1:0] base;
  logic [4:0]         sh;

  always_comb begin
    case (size)
      SZ_BYTE: begin base = DWORD_W'(8'hFF);    sh = {lane, 3'b000}; end
      SZ_HALF: begin base = DWORD_W'(16'hFFFF); sh = {lane, 3'b000}; end
      default: begin base = '1;                 sh = 5'd0;           end
    endcase
    rd_data = (win_data >> sh) & base;
    merged  = (win_data & ~(base << sh)) | ((new_data & base) << sh);
  end
endmodule

// File: rtl/cfgseq_waitcnt.sv
module cfgseq_waitcnt #(
  parameter int LOAD = 25000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic zero
);
  localparam int CNT_W = $clog2(LOAD + 1);
  localparam logic [CNT_W-1:0] LOAD_M1 = CNT_W'(LOAD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (start)        cnt_q <= LOAD_M1;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/cfg_cycle_seq.sv
module cfg_cycle_seq
  import cfgseq_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int WAIT_US     = 500,
  parameter int SLOT_W      = 4,
  parameter int FUNC_W      = 2,
  parameter int REG_W       = 4,
  parameter int BRIDGE_SLOT = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_root,
  input  logic [4:0]  req_slot,
  input  logic [2:0]  req_func,
  input  logic [7:0]  req_where,
  input  logic [1:0]  req_size,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  output logic        busy,
  output logic        rsp_valid,
  output logic        rsp_notfound,
  output logic [31:0] rsp_rdata,
  output logic        bus_wr,
  output logic        bus_rd,
  output logic        bus_win,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata
);
  localparam int WAIT_CYC_RAW = (CLK_HZ / 1_000_000) * WAIT_US;
  localparam int WAIT_CYC     = (WAIT_CYC_RAW < 1) ? 1 : WAIT_CYC_RAW;

  seq_state_e         state_q;
  logic [1:0]         size_q, lane_q;
  logic               wr_q;
  logic [DWORD_W-1:0] wdata_q;

  logic               enc_ok;
  logic [DWORD_W-1:0] enc_ctrl;
  logic [DWORD_W-1:0] lane_rd, lane_merged;
  logic               wait_zero;

  cfgseq_encode #(
    .SLOT_W(SLOT_W), .FUNC_W(FUNC_W), .REG_W(REG_W), .BRIDGE_SLOT(BRIDGE_SLOT)
  ) u_encode (
    .root(req_root), .slot(req_slot), .func(req_func), .where_b(req_where),
    .ok(enc_ok), .ctrl(enc_ctrl)
  );

  cfgseq_lane u_lane (
    .size(size_q), .lane(lane_q), .win_data(bus_rdata), .new_data(wdata_q),
    .rd_data(lane_rd), .merged(lane_merged)
  );

  cfgseq_waitcnt #(.LOAD(WAIT_CYC)) u_wait (
    .clk(clk), .rst(rst), .start(state_q == S_WRWIN), .zero(wait_zero)
  );

  assign busy = (state_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      size_q       <= '0;
      lane_q       <= '0;
      wr_q         <= 1'b0;
      wdata_q      <= '0;
      rsp_valid    <= 1'b0;
      rsp_notfound <= 1'b0;
      rsp_rdata    <= '0;
      bus_wr       <= 1'b0;
      bus_rd       <= 1'b0;
      bus_win      <= 1'b0;
      bus_wdata    <= '0;
    end else begin
      bus_wr <= 1'b0;
      bus_rd <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            size_q    <= req_size;
            lane_q    <= req_where[1:0];
            wr_q      <= req_write;
            wdata_q   <= req_wdata;
            rsp_rdata <= '0;
            if (!enc_ok) begin
              rsp_valid    <= 1'b1;
              rsp_notfound <= 1'b1;
              state_q      <= S_RESP;
            end else begin
              rsp_notfound <= 1'b0;
              bus_wr       <= 1'b1;
              bus_win      <= 1'b0;
              bus_wdata    <= enc_ctrl;
              state_q      <= S_CTRL;
            end
          end
        end
        S_CTRL: begin
          bus_rd  <= 1'b1;
          bus_win <= 1'b1;
          state_q <= S_RDREQ;
        end
        S_RDREQ: state_q <= S_RDCAP;
        S_RDCAP: begin
          bus_wr <= 1'b1;
          if (wr_q) begin
            bus_win   <= 1'b1;
            bus_wdata <= lane_merged;
            state_q   <= S_WRWIN;
          end else begin
            rsp_rdata <= lane_rd;
            bus_win   <= 1'b0;
            bus_wdata <= '0;
            state_q   <= S_REST;
          end
        end
        S_WRWIN: state_q <= S_WAIT;
        S_WAIT: begin
          if (wait_zero) begin
            bus_wr    <= 1'b1;
            bus_win   <= 1'b0;
            bus_wdata <= '0;
            state_q   <= S_REST;
          end
        end
        S_REST: begin
          rsp_valid <= 1'b1;
          state_q   <= S_RESP;
        end
        S_RESP: begin
          rsp_valid <= 1'b0;
          state_q   <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgseq_checker.sv
module cfgseq_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        busy,
  input logic        rsp_valid,
  input logic        rsp_notfound,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic        bus_win,
  input logic [31:0] bus_wdata
);
  logic restore;
  assign restore = bus_wr && !bus_win && (bus_wdata == 32'd0);

  // R3: a refusal answers in the cycle right after acceptance
  assert_refuse_next_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_notfound) |-> $past(req_valid && !busy));

  // R5: only one strobe at a time, and reads only hit the window
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));
  assert_read_window_R5: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> bus_win);
  assert_read_gap_R5: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> (!bus_rd && !bus_wr));

  // R1: a non-zero control write carries use-register and config-select
  assert_ctrl_flags_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_win && bus_wdata != 32'd0) |-> (bus_wdata[1:0] == 2'b11));

  // R10: the restore write is followed by a good response
  assert_restore_then_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    restore |=> (rsp_valid && !rsp_notfound));

  // R10: the response is a single pulse and frees the sequencer
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (!rsp_valid && !busy));

  // R9: the bus is quiet whenever the sequencer is idle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!bus_wr && !bus_rd));
endmodule

bind cfg_cycle_seq cfgseq_checker u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_notfound(rsp_notfound),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_win(bus_win), .bus_wdata(bus_wdata)
);

// File: tb/cfg_cycle_seq_tb.sv
module cfg_cycle_seq_tb;
  localparam int CLK_HZ   = 50_000_000;
  localparam int WAIT_US  = 2;
  localparam int WAIT_CYC = 100;
  localparam int BRIDGE   = 8;

  logic        clk, rst;
  logic        req_valid, req_root, req_write;
  logic [4:0]  req_slot;
  logic [2:0]  req_func;
  logic [7:0]  req_where;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        busy, rsp_valid, rsp_notfound;
  logic [31:0] rsp_rdata;
  logic        bus_wr, bus_rd, bus_win;
  logic [31:0] bus_wdata, bus_rdata;

  cfg_cycle_seq #(.CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US), .SLOT_W(4), .FUNC_W(2),
                  .REG_W(4), .BRIDGE_SLOT(BRIDGE)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_root(req_root),
    .req_slot(req_slot), .req_func(req_func), .req_where(req_where),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_notfound(rsp_notfound),
    .rsp_rdata(rsp_rdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_win(bus_win),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int vectors = 0;
  int miss    = 0;
  int cyc     = 0;
  int last_strobe = 0;

  typedef struct {
    bit          wr;
    bit          win;
    logic [31:0] data;
    int          gap;
    string       tag;
  } ev_t;
  ev_t q[$];

  logic [31:0] mem [int unsigned];
  logic [31:0] ctrl_reg;

  function automatic logic [31:0] peek(logic [31:0] k);
    if (mem.exists(k)) return mem[k];
    return k * 32'h9E3779B1;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // register-bus slave model: control register plus window-addressed storage
  always @(posedge clk) begin
    if (rst) begin
      ctrl_reg  <= 32'd0;
      bus_rdata <= 32'd0;
    end else begin
      if (bus_wr && !bus_win) ctrl_reg <= bus_wdata;
      if (bus_wr && bus_win)  mem[ctrl_reg] = bus_wdata;
      if (bus_rd)             bus_rdata <= peek(ctrl_reg);
    end
  end

  // strobe monitor against the expected event queue, every clock
  always @(negedge clk) begin
    if (!rst && (bus_wr || bus_rd)) begin
      if (q.size() == 0) begin
        check(1'b0, "R5/R9 unexpected strobe", {30'd0, bus_wr, bus_rd}, 32'd0);
      end else begin
        ev_t e;
        e = q.pop_front();
        check(bus_wr == e.wr && bus_rd == !e.wr && bus_win == e.win,
              {e.tag, " strobe kind"}, {29'd0, bus_wr, bus_rd, bus_win},
              {29'd0, e.wr, !e.wr, e.win});
        if (e.wr) check(bus_wdata == e.data, {e.tag, " write data"}, bus_wdata, e.data);
        if (e.gap > 0)
          check(cyc - last_strobe == e.gap, {e.tag, " strobe timing"},
                32'(cyc - last_strobe), 32'(e.gap));
      end
      last_strobe = cyc;
    end
  end

  task automatic do_req(bit root, logic [4:0] slot, logic [2:0] func,
                        logic [7:0] where_b, logic [1:0] size, bit wr,
                        logic [31:0] wdata, string tag);
    bit          bad;
    logic [31:0] ctrlw, old, base, exp_rd, merged;
    int          sh;
    ev_t         e;
    while (busy) @(negedge clk);
    bad = (slot > 15) || (func > 3) || ((where_b >> 2) > 15) || (root && slot == BRIDGE);
    ctrlw = (32'(slot) << 9) | (32'(func) << 7) | (32'(where_b >> 2) << 3) |
            (root ? 32'd0 : 32'd4) | 32'd3;
    old  = peek(ctrlw);
    base = (size == 0) ? 32'hFF : (size == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    sh   = (size >= 2) ? 0 : int'(where_b[1:0]) * 8;
    exp_rd = (old >> sh) & base;
    merged = (old & ~(base << sh)) | ((wdata & base) << sh);
    if (!bad) begin
      e = '{1'b1, 1'b0, ctrlw, 0, {tag, " R1 control"}};         q.push_back(e);
      e = '{1'b0, 1'b1, 32'd0, 1, {tag, " R5 window read"}};     q.push_back(e);
      if (wr) begin
        e = '{1'b1, 1'b1, merged, 2, {tag, " R7 window write"}};  q.push_back(e);
        e = '{1'b1, 1'b0, 32'd0, WAIT_CYC + 1, {tag, " R8 restore"}}; q.push_back(e);
      end else begin
        e = '{1'b1, 1'b0, 32'd0, 2, {tag, " R5 restore"}};        q.push_back(e);
      end
    end
    req_root = root; req_slot = slot; req_func = func; req_where = where_b;
    req_size = size; req_write = wr; req_wdata = wdata; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      check(rsp_valid == 1'b1, {tag, " R3 refusal timing"}, {31'd0, rsp_valid}, 32'd1);
    end else begin
      while (!rsp_valid) @(negedge clk);
      check(cyc - last_strobe == 1, {tag, " R10 response timing"},
            32'(cyc - last_strobe), 32'd1);
    end
    check(rsp_notfound == bad, {tag, " R3/R4 status"}, {31'd0, rsp_notfound}, {31'd0, bad});
    check(rsp_rdata == ((bad || wr) ? 32'd0 : exp_rd), {tag, " R6 read data"},
          rsp_rdata, (bad || wr) ? 32'd0 : exp_rd);
    @(negedge clk);
    check(!busy && !rsp_valid, {tag, " R10 release"}, {30'd0, busy, rsp_valid}, 32'd0);
    check(q.size() == 0, {tag, " R5 all phases seen"}, 32'(q.size()), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_root = 1'b1; req_slot = '0; req_func = '0;
    req_where = '0; req_size = '0; req_write = 1'b0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!busy && !rsp_valid && !bus_wr && !bus_rd, "R10 reset state",
          {28'd0, busy, rsp_valid, bus_wr, bus_rd}, 32'd0);
    @(negedge clk);

    do_req(1, 5'd1, 3'd0, 8'h00, 2'd2, 0, 32'd0,        "R1 R2 dword read");
    do_req(1, 5'd1, 3'd0, 8'h04, 2'd2, 1, 32'h1122_3344, "R7 dword write");
    do_req(1, 5'd1, 3'd0, 8'h04, 2'd2, 0, 32'd0,        "R6 dword readback");
    do_req(1, 5'd1, 3'd0, 8'h05, 2'd0, 1, 32'hFFFF_FFAB, "R7 byte write lane1");
    do_req(1, 5'd1, 3'd0, 8'h04, 2'd2, 0, 32'd0,        "R7 merge readback");
    do_req(1, 5'd1, 3'd0, 8'h05, 2'd0, 0, 32'd0,        "R6 byte read lane1");
    do_req(1, 5'd1, 3'd0, 8'h06, 2'd1, 0, 32'd0,        "R6 half read lane2");
    do_req(1, 5'd1, 3'd0, 8'h07, 2'd1, 0, 32'd0,        "R6 half read lane3");
    do_req(0, 5'd2, 3'd1, 8'h10, 2'd2, 0, 32'd0,        "R1 type1 read");
    do_req(1, 5'd8, 3'd0, 8'h00, 2'd2, 0, 32'd0,        "R4 bridge slot root");
    do_req(0, 5'd8, 3'd0, 8'h00, 2'd2, 0, 32'd0,        "R4 bridge slot nonroot");
    do_req(1, 5'd16, 3'd0, 8'h00, 2'd2, 0, 32'd0,       "R3 slot over");
    do_req(1, 5'd1, 3'd4, 8'h00, 2'd2, 0, 32'd0,        "R3 func over");
    do_req(1, 5'd1, 3'd0, 8'h40, 2'd2, 0, 32'd0,        "R3 reg over");
    do_req(1, 5'd15, 3'd3, 8'h3C, 2'd2, 0, 32'd0,       "R3 max legal read");

    fork
      do_req(1, 5'd3, 3'd2, 8'h2E, 2'd1, 1, 32'h0000_BEEF, "R8 half write lane2");
      begin
        repeat (30) @(negedge clk);
        req_root = 1'b1; req_slot = 5'd4; req_func = 3'd0; req_where = 8'h00;
        req_size = 2'd2; req_write = 1'b1; req_wdata = 32'h5555_5555;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    do_req(1, 5'd3, 3'd2, 8'h2C, 2'd2, 0, 32'd0,        "R9 readback after poke");
    do_req(1, 5'd4, 3'd0, 8'h00, 2'd2, 0, 32'd0,        "R9 poked target untouched");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule